// File: doc/BRIEF.md
# GPIB Primary Address Recognizer

This block watches the command bytes that a GPIB controller places on the data lines while ATN is asserted. It picks out the addressed commands that concern this device: its own listen address, its own talk address, unlisten, untalk, and talk addresses meant for other devices. It compares addressed commands with the 5-bit primary address set on the device's address switch, and from them keeps two state flags: addressed-to-listen and addressed-to-talk. The listen flag goes to the handshake logic, which uses it to decide whether to accept data messages. The two indicator enables follow the flags so that front-panel lamps show the addressed state.

When the device is addressed to talk, the talk-request output is raised at once. Measurement data may be sent only after the controller releases ATN. The block marks that moment with a one-cycle talk-ready pulse, which the data output path uses as its start signal. Secondary addresses, polls and device clear are handled elsewhere. Commands in those groups pass through here with no effect.

Top module: `gpib_addr_recognizer`

## Requirements
- R1: During and after reset, listen_on, talk_req, listen_lamp, talk_lamp and talk_ready are all 0.
- R2: A strobed byte with ATN high whose low seven bits equal 0x20 + addr_sw (own listen address) sets listen_on and listen_lamp from the next cycle.
- R3: A strobed byte with ATN high whose low seven bits equal 0x3F (unlisten) clears listen_on and listen_lamp from the next cycle.
- R4: A strobed byte with ATN high whose low seven bits equal 0x40 + addr_sw (own talk address) sets talk_req and talk_lamp from the next cycle.
- R5: A strobed byte with ATN high whose low seven bits equal 0x5F (untalk) clears talk_req and talk_lamp from the next cycle.
- R6: A strobed talk address 0x40 + N with ATN high, where N differs from addr_sw and N is not 31, clears talk_req and talk_lamp and leaves listen_on unchanged.
- R7: Bit 7 of cmd_byte has no effect on decoding. 0xC5 acts as 0x45, and 0xBF acts as 0x3F.
- R8: A switch setting of 31 matches no listen or talk address. 0x3F and 0x5F still act as unlisten and untalk.
- R9: A byte has no effect unless cmd_valid and atn are both high in the same cycle.
- R10: talk_ready is high for exactly one cycle, in the cycle after the first rising clock edge at which talk_req is 1 and atn is 0. It rises again only after atn has been high or talk_req has been 0 in between.
- R11: The listen and talk flags are independent, so a talk command leaves listen_on unchanged and a listen command leaves talk_req unchanged. Bytes whose bits 6:5 are 00 or 11 change neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Byte-valid strobe, one cycle per received byte |
| cmd_byte | input | 8 | Received byte from the data lines |
| atn | input | 1 | Attention line, high while the controller sends commands |
| addr_sw | input | 5 | Primary address from the address switch (31 disables recognition) |
| listen_on | output | 1 | Device is addressed to listen |
| talk_req | output | 1 | Device is addressed to talk and requests the data-available handshake |
| listen_lamp | output | 1 | Listen indicator enable |
| talk_lamp | output | 1 | Talk indicator enable |
| talk_ready | output | 1 | One-cycle pulse when data output may begin |

## Verification
A command sampled at a rising edge changes the flags and lamps just after that same edge, so each table vector is driven on the falling edge and checked a short delay after the following rising edge. The talk-ready pulse has one more register in its path. The bench therefore releases ATN on a falling edge, expects the pulse after the next rising edge, and expects it to be gone one edge later. Vectors with no effect are followed by a check of both flags in the same slot, which shows at the ports that nothing changed.

// File: rtl/gar_pkg.sv
package gar_pkg;
  localparam int ADDR_W = 5;
  localparam int CMD_W  = 8;
  localparam int GRP_LO = ADDR_W;
  localparam int GRP_HI = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] ADDR_NONE = '1;
  localparam logic [1:0] GRP_LISTEN = 2'b01;
  localparam logic [1:0] GRP_TALK   = 2'b10;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_MY_LISTEN,
    CMD_UNLISTEN,
    CMD_MY_TALK,
    CMD_UNTALK,
    CMD_OTHER_TALK
  } cmd_kind_e;

  // Classify the low GRP_HI+1 bits of a command byte against the switch.
  function automatic cmd_kind_e classify(logic [GRP_HI:0] b, logic [ADDR_W-1:0] sw);
    logic [1:0]        grp;
    logic [ADDR_W-1:0] a;
    logic              sw_ok;
    cmd_kind_e         k;
    grp   = b[GRP_HI:GRP_LO];
    a     = b[ADDR_W-1:0];
    sw_ok = (sw != ADDR_NONE);
    k     = CMD_NONE;
    if (grp == GRP_LISTEN) begin
      if (a == ADDR_NONE)          k = CMD_UNLISTEN;
      else if (sw_ok && a == sw)   k = CMD_MY_LISTEN;
    end else if (grp == GRP_TALK) begin
      if (a == ADDR_NONE)          k = CMD_UNTALK;
      else if (sw_ok && a == sw)   k = CMD_MY_TALK;
      else                         k = CMD_OTHER_TALK;
    end
    return k;
  endfunction
endpackage

// File: rtl/gar_cmd_decode.sv
module gar_cmd_decode
  import gar_pkg::*;
(
  input  logic              cmd_valid,
  input  logic              atn,
  input  logic [CMD_W-1:0]  cmd_byte,
  input  logic [ADDR_W-1:0] addr_sw,
  output cmd_kind_e         kind
);
  logic take;
  logic unused_hi_bits;

  assign take           = cmd_valid & atn;
  assign unused_hi_bits = ^cmd_byte[CMD_W-1:GRP_HI+1];
  assign kind           = take ? classify(cmd_byte[GRP_HI:0], addr_sw) : CMD_NONE;
endmodule

// File: rtl/gar_addr_flags.sv
module gar_addr_flags
  import gar_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cmd_kind_e kind,
  output logic      listen_q,
  output logic      talk_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      listen_q <= 1'b0;
      talk_q   <= 1'b0;
    end else begin
      case (kind)
        CMD_MY_LISTEN:              listen_q <= 1'b1;
        CMD_UNLISTEN:               listen_q <= 1'b0;
        CMD_MY_TALK:                talk_q   <= 1'b1;
        CMD_UNTALK, CMD_OTHER_TALK: talk_q   <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gar_ready_edge.sv
module gar_ready_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic talk_q,
  input  logic atn,
  output logic ready_pulse
);
  logic open_now;
  logic open_q;

  assign open_now = talk_q & ~atn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      ready_pulse <= 1'b0;
    end else begin
      open_q      <= open_now;
      ready_pulse <= open_now & ~open_q;
    end
  end
endmodule

// File: rtl/gpib_addr_recognizer.sv
module gpib_addr_recognizer
  import gar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_byte,
  input  logic              atn,
  input  logic [ADDR_W-1:0] addr_sw,
  output logic              listen_on,
  output logic              talk_req,
  output logic              listen_lamp,
  output logic              talk_lamp,
  output logic              talk_ready
);
  cmd_kind_e dec_kind;
  logic      listen_q;
  logic      talk_q;

  gar_cmd_decode i_dec (
    .cmd_valid (cmd_valid),
    .atn       (atn),
    .cmd_byte  (cmd_byte),
    .addr_sw   (addr_sw),
    .kind      (dec_kind)
  );

  gar_addr_flags i_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (dec_kind),
    .listen_q (listen_q),
    .talk_q   (talk_q)
  );

  gar_ready_edge i_ready (
    .clk         (clk),
    .rst_n       (rst_n),
    .talk_q      (talk_q),
    .atn         (atn),
    .ready_pulse (talk_ready)
  );

  assign listen_on   = listen_q;
  assign listen_lamp = listen_q;
  assign talk_req    = talk_q;
  assign talk_lamp   = talk_q;
endmodule

// File: rtl/gar_checker.sv
module gar_checker
  import gar_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              atn,
  input logic              cmd_valid,
  input logic [ADDR_W-1:0] addr_sw,
  input cmd_kind_e         dec_kind,
  input logic              listen_on,
  input logic              talk_req,
  input logic              talk_ready
);
  AST_LISTEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dec_kind == CMD_MY_LISTEN |=> listen_on); // R2
  AST_UNLISTEN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    dec_kind == CMD_UNLISTEN |=> !listen_on); // R3
  AST_TALK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dec_kind == CMD_MY_TALK |=> talk_req); // R4
  AST_UNTALK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    dec_kind == CMD_UNTALK |=> !talk_req); // R5
  AST_OTHER_TALK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    dec_kind == CMD_OTHER_TALK |=> !talk_req && $stable(listen_on)); // R6
  AST_SW_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_sw == ADDR_NONE && !listen_on && !talk_req) |=> !listen_on && !talk_req); // R8
  AST_NO_ATN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && atn) |=> $stable(listen_on) && $stable(talk_req)); // R9
  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    talk_ready |=> !talk_ready); // R10
  AST_READY_NEEDS_TALK: assert property (@(posedge clk) disable iff (!rst_n)
    talk_ready |-> talk_req && !$past(atn)); // R10
endmodule

bind gpib_addr_recognizer gar_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .atn        (atn),
  .cmd_valid  (cmd_valid),
  .addr_sw    (addr_sw),
  .dec_kind   (dec_kind),
  .listen_on  (listen_on),
  .talk_req   (talk_req),
  .talk_ready (talk_ready)
);

// File: tb/test_gpib_addr_recognizer.sv
module test_gpib_addr_recognizer;
  localparam int CLK_P = 10;
  localparam int NV    = 21;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       atn = 1'b0;
  logic [4:0] addr_sw = 5'd5;
  logic       listen_on, talk_req, listen_lamp, talk_lamp, talk_ready;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gpib_addr_recognizer i_gpib_addr_recognizer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .atn(atn), .addr_sw(addr_sw), .listen_on(listen_on), .talk_req(talk_req),
    .listen_lamp(listen_lamp), .talk_lamp(talk_lamp), .talk_ready(talk_ready)
  );

  // {valid, atn, switch, byte, expected listen, expected talk}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1,1'b1,5'd5, 8'h25,1'b1,1'b0},  // R2 own listen
    {1'b1,1'b1,5'd5, 8'h3F,1'b0,1'b0},  // R3 unlisten
    {1'b1,1'b1,5'd5, 8'h25,1'b1,1'b0},  // R2
    {1'b1,1'b1,5'd5, 8'h45,1'b1,1'b1},  // R4 R11 own talk keeps listen
    {1'b1,1'b1,5'd5, 8'h5F,1'b1,1'b0},  // R5 untalk
    {1'b1,1'b1,5'd5, 8'h45,1'b1,1'b1},  // R4
    {1'b1,1'b1,5'd5, 8'h47,1'b1,1'b0},  // R6 other talker
    {1'b1,1'b1,5'd5, 8'hC5,1'b1,1'b1},  // R7 bit 7 set, talk
    {1'b1,1'b1,5'd5, 8'hBF,1'b0,1'b1},  // R7 bit 7 set, unlisten
    {1'b0,1'b1,5'd5, 8'h25,1'b0,1'b1},  // R9 no strobe
    {1'b1,1'b0,5'd5, 8'h25,1'b0,1'b1},  // R9 no atn
    {1'b1,1'b1,5'd5, 8'h5F,1'b0,1'b0},  // R5
    {1'b1,1'b1,5'd0, 8'h20,1'b1,1'b0},  // R2 address 0
    {1'b1,1'b1,5'd0, 8'h40,1'b1,1'b1},  // R4 address 0
    {1'b1,1'b1,5'd31,8'h40,1'b1,1'b0},  // R8 R6 switch 31, address 0 is other
    {1'b1,1'b1,5'd31,8'h3F,1'b0,1'b0},  // R8 unlisten still works
    {1'b1,1'b1,5'd31,8'h20,1'b0,1'b0},  // R8 no match
    {1'b1,1'b1,5'd30,8'h3E,1'b1,1'b0},  // R2 address 30
    {1'b1,1'b1,5'd30,8'h05,1'b1,1'b0},  // R11 group 00 ignored
    {1'b1,1'b1,5'd30,8'h7E,1'b1,1'b0},  // R11 group 11 ignored
    {1'b1,1'b1,5'd30,8'h5E,1'b1,1'b1}   // R4 address 30
  };

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 listen_on", listen_on, 1'b0);
    chk("R1 talk_req", talk_req, 1'b0);
    chk("R1 talk_ready", talk_ready, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cmd_valid = VEC[i][16];
      atn       = VEC[i][15];
      addr_sw   = VEC[i][14:10];
      cmd_byte  = VEC[i][9:2];
      tick();
      chk($sformatf("R2-vec%0d listen_on", i), listen_on, VEC[i][1]);
      chk($sformatf("R4-vec%0d talk_req", i), talk_req, VEC[i][0]);
      chk("R2 listen_lamp follows", listen_lamp, VEC[i][1]);
      chk("R4 talk_lamp follows", talk_lamp, VEC[i][0]);
    end

    // R10: talk flag set, ATN still high -> no pulse
    @(negedge clk) cmd_valid = 1'b0;
    tick();
    chk("R10 no pulse while atn", talk_ready, 1'b0);
    @(negedge clk) atn = 1'b0;
    tick();
    chk("R10 pulse after atn release", talk_ready, 1'b1);
    tick();
    chk("R10 pulse one cycle", talk_ready, 1'b0);
    tick();
    chk("R10 no repeat", talk_ready, 1'b0);
    @(negedge clk) atn = 1'b1;
    tick();
    chk("R10 quiet on atn return", talk_ready, 1'b0);
    @(negedge clk) atn = 1'b0;
    tick();
    chk("R10 re-armed pulse", talk_ready, 1'b1);
    chk("R9 flags kept with atn low", talk_req, 1'b1);

    // R10: after untalk, releasing ATN gives no pulse
    @(negedge clk) begin atn = 1'b1; cmd_valid = 1'b1; cmd_byte = 8'h5F; end
    tick();
    @(negedge clk) begin cmd_valid = 1'b0; atn = 1'b0; end
    tick();
    chk("R10 no pulse when not talker", talk_ready, 1'b0);

    // R1: reset in the middle of operation
    @(negedge clk) begin atn = 1'b1; cmd_valid = 1'b1; cmd_byte = 8'h3E; end
    tick();
    chk("R2 listen before reset", listen_on, 1'b1);
    @(negedge clk) begin rst_n = 1'b0; cmd_valid = 1'b0; end
    tick();
    chk("R1 listen cleared by reset", listen_on, 1'b0);
    chk("R1 listen_lamp cleared by reset", listen_lamp, 1'b0);
    chk("R1 talk_lamp cleared by reset", talk_lamp, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule